// File: doc/BRIEF.md
# JTAG Scan Trace Monitor

The monitor listens to the five lines of a JTAG port (clock, mode select, data in, data out and the active-low test reset) without driving any of them. A fast system clock oversamples every line through a two-stage synchronizer. A rising edge on the synchronized test clock is detected, and that edge advances a shadow copy of the sixteen-state TAP controller using the mode-select value taken at the same edge. The test clock is never used as a clock inside the block.

While the shadow controller is in a shift state, the monitor counts edges and collects the data-in and data-out bits, least significant bit first. It emits one trace record for each completed scan. It also emits one record for each unbroken stay in Test-Logic-Reset or Run-Test/Idle, carrying the number of clock edges spent there. Records leave through a valid/ready port. A trace host formats and stores them.

Top module: `jtag_scan_monitor`

## Requirements
- R1: The shadow TAP state changes only on a detected rising edge of the synchronized test clock, and follows the standard TAP transition table using the mode-select value sampled at that edge; toggling mode select or data while the test clock is steady yields no record.
- R2: While the synchronized test reset is low, the shadow state is held at Test-Logic-Reset, the current instruction is set to RESET_INSTR (default 0x08), clock edges are ignored, and a scan or dwell in progress is abandoned without a record.
- R3: On the edge that enters Update-DR, a record with kind 3 is emitted. Its count is the number of edges sampled in Shift-DR, and zero is allowed. Its data-in and data-out words are right-aligned, with bit 0 holding the first bit shifted. Its instruction field is the current instruction.
- R4: When a scan shifts more than DATA_W (64) bits, the count keeps counting, only the first 64 bits are kept, and the overflow flag of the record is 1. For shorter scans the flag is 0.
- R5: A stay in Test-Logic-Reset (kind 0) or Run-Test/Idle (kind 1) produces one record, on the edge that leaves the state. Its count is the number of edges sampled while in that state, the leaving edge included. The data words and the overflow flag are 0.
- R6: On the edge that enters Update-IR, a record with kind 2 is emitted, shaped like R3, using Shift-IR edges. The low IR_W bits of its right-aligned data-in word become the current instruction, and the record reports that new value.
- R7: Entering Test-Logic-Reset through the mode-select line sets the current instruction to RESET_INSTR.
- R8: While rec_valid is high and rec_ready is low, the record outputs hold steady. A record that completes in that situation is discarded, and drop_count increments, saturating at its maximum.
- R9: After the system reset, rec_valid and drop_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed serial data toward the target |
| tdo_i | input | 1 | Observed serial data from the target |
| trst_n_i | input | 1 | Observed active-low test reset |
| rec_ready | input | 1 | Trace sink accepts the record |
| rec_valid | output | 1 | A record is presented |
| rec_kind | output | 2 | 0 reset dwell, 1 idle dwell, 2 instruction scan, 3 data scan |
| rec_count | output | CNT_W | Dwell edges or shifted bits |
| rec_tdi | output | DATA_W | Right-aligned data-in word |
| rec_tdo | output | DATA_W | Right-aligned data-out word |
| rec_instr | output | IR_W | Instruction in force, or the new instruction for kind 2 |
| rec_ovf | output | 1 | Scan was longer than DATA_W |
| drop_count | output | DROP_W | Records discarded for back-pressure |

## Verification
The assertions watch, on every cycle, the rules that need no memory of the scan itself. The shadow state may move only on a detected edge, and the test reset forces it. The reset instruction goes with the reset state. The output must hold under back-pressure, and the drop counter must never fall. The overflow flag must agree with the reported count, and dwell records must be non-empty. Only the bench scenarios can show the content of the records. A sweep of data scan lengths from 0 to 70 and of instruction scans from 1 to 8 bits, with computed bit patterns, checks that the collected words, the counts, the instruction tracking and the dwell lengths match what the pin activity implies.

// File: rtl/jtag_scan_monitor.sv
module jtag_scan_monitor #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int IR_W   = 5,
  parameter int DROP_W = 16,
  parameter logic [IR_W-1:0] RESET_INSTR = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck_i,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic              tdo_i,
  input  logic              trst_n_i,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [1:0]        rec_kind,
  output logic [CNT_W-1:0]  rec_count,
  output logic [DATA_W-1:0] rec_tdi,
  output logic [DATA_W-1:0] rec_tdo,
  output logic [IR_W-1:0]   rec_instr,
  output logic              rec_ovf,
  output logic [DROP_W-1:0] drop_count
);

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_t;

  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_W);

  logic [4:0] sync1, sync2;
  logic       tck_q;
  tap_t       state, nxt;
  logic [IR_W-1:0]   instr;
  logic [CNT_W-1:0]  dwell, scnt;
  logic [DATA_W-1:0] sh_di, sh_do, di_al, do_al;
  logic              ovf;

  wire tck_s    = sync2[4];
  wire tms_s    = sync2[3];
  wire tdi_s    = sync2[2];
  wire tdo_s    = sync2[1];
  wire trst_s   = sync2[0];
  wire tck_rise = tck_s & ~tck_q;

  wire in_dwell  = (state == S_TLR) || (state == S_RTI);
  wire in_shift  = (state == S_SH_DR) || (state == S_SH_IR);
  wire leave_dw  = in_dwell && (nxt != state);
  wire to_upd_ir = (nxt == S_UPD_IR);
  wire to_upd_dr = (nxt == S_UPD_DR);
  wire ev        = tck_rise && trst_s && (leave_dw || to_upd_ir || to_upd_dr);

  wire [CNT_W-1:0] dwell_inc = (dwell == '1) ? dwell : dwell + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      tck_q <= 1'b0;
    end else begin
      sync1 <= {tck_i, tms_i, tdi_i, tdo_i, trst_n_i};
      sync2 <= sync1;
      tck_q <= tck_s;
    end
  end

  always_comb begin
    case (state)
      S_TLR:    nxt = tms_s ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms_s ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms_s ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms_s ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms_s ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms_s ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms_s ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms_s ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms_s ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms_s ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms_s ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms_s ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms_s ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms_s ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms_s ? S_UPD_IR : S_SH_IR;
      default:  nxt = tms_s ? S_SEL_DR : S_RTI;
    endcase
  end

  always_comb begin
    if (scnt >= DATA_LIM) begin
      di_al = sh_di;
      do_al = sh_do;
    end else if (scnt == '0) begin
      di_al = '0;
      do_al = '0;
    end else begin
      di_al = sh_di >> (DATA_LIM - scnt);
      do_al = sh_do >> (DATA_LIM - scnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !trst_s) begin
      state <= S_TLR;
      instr <= RESET_INSTR;
      dwell <= '0;
      scnt  <= '0;
      ovf   <= 1'b0;
      if (!rst_n) begin
        sh_di <= '0;
        sh_do <= '0;
      end
    end else if (tck_rise) begin
      state <= nxt;
      if (in_dwell) dwell <= leave_dw ? '0 : dwell_inc;
      if (nxt == S_CAP_DR || nxt == S_CAP_IR) begin
        scnt  <= '0;
        ovf   <= 1'b0;
        sh_di <= '0;
        sh_do <= '0;
      end
      if (in_shift) begin
        if (scnt < DATA_LIM) begin
          sh_di <= {tdi_s, sh_di[DATA_W-1:1]};
          sh_do <= {tdo_s, sh_do[DATA_W-1:1]};
        end else begin
          ovf <= 1'b1;
        end
        if (scnt != '1) scnt <= scnt + CNT_W'(1);
      end
      if (nxt == S_TLR)  instr <= RESET_INSTR;
      else if (to_upd_ir) instr <= di_al[IR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid  <= 1'b0;
      rec_kind   <= '0;
      rec_count  <= '0;
      rec_tdi    <= '0;
      rec_tdo    <= '0;
      rec_instr  <= '0;
      rec_ovf    <= 1'b0;
      drop_count <= '0;
    end else if (ev) begin
      if (rec_valid && !rec_ready) begin
        if (drop_count != '1) drop_count <= drop_count + DROP_W'(1);
      end else begin
        rec_valid <= 1'b1;
        rec_kind  <= leave_dw ? {1'b0, state == S_RTI} : {1'b1, to_upd_dr};
        rec_count <= leave_dw ? dwell_inc : scnt;
        rec_tdi   <= leave_dw ? '0 : di_al;
        rec_tdo   <= leave_dw ? '0 : do_al;
        rec_instr <= to_upd_ir ? di_al[IR_W-1:0] : instr;
        rec_ovf   <= leave_dw ? 1'b0 : ovf;
      end
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_scan_monitor_chk.sv
module jtag_scan_monitor_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int IR_W   = 5,
  parameter int DROP_W = 16,
  parameter logic [IR_W-1:0] RESET_INSTR = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trst_s,
  input logic              tck_rise,
  input logic [3:0]        state,
  input logic [IR_W-1:0]   instr,
  input logic              rec_ready,
  input logic              rec_valid,
  input logic [1:0]        rec_kind,
  input logic [CNT_W-1:0]  rec_count,
  input logic [DATA_W-1:0] rec_tdi,
  input logic [DATA_W-1:0] rec_tdo,
  input logic [IR_W-1:0]   rec_instr,
  input logic              rec_ovf,
  input logic [DROP_W-1:0] drop_count
);

  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_W);

  AST_STATE_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (trst_s && !tck_rise) |=> $stable(state)); // R1

  AST_TRST_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_s |=> (state == 4'd0) && (instr == RESET_INSTR)); // R2

  AST_OVF_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind[1]) |-> (rec_ovf == (rec_count > DATA_LIM))); // R4

  AST_DWELL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_kind[1]) |-> (rec_count != '0) && !rec_ovf); // R5

  AST_RESET_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd0) |-> (instr == RESET_INSTR)); // R7

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid &&
      $stable({rec_kind, rec_count, rec_tdi, rec_tdo, rec_instr, rec_ovf})); // R8

  AST_DROP_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count)); // R8

endmodule

bind jtag_scan_monitor jtag_scan_monitor_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .IR_W(IR_W), .DROP_W(DROP_W), .RESET_INSTR(RESET_INSTR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trst_s(trst_s), .tck_rise(tck_rise), .state(state),
  .instr(instr), .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_kind(rec_kind),
  .rec_count(rec_count), .rec_tdi(rec_tdi), .rec_tdo(rec_tdo), .rec_instr(rec_instr),
  .rec_ovf(rec_ovf), .drop_count(drop_count)
);

// File: tb/tb_jtag_scan_monitor.sv
module tb_jtag_scan_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, tdo = 1'b0, trst_n = 1'b1;
  logic rec_ready = 1'b1;
  logic rec_valid, rec_ovf;
  logic [1:0]  rec_kind;
  logic [15:0] rec_count, drop_count;
  logic [63:0] rec_tdi, rec_tdo;
  logic [4:0]  rec_instr;

  always #5 clk = ~clk;

  jtag_scan_monitor dut (
    .clk(clk), .rst_n(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .tdo_i(tdo),
    .trst_n_i(trst_n), .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .rec_count(rec_count), .rec_tdi(rec_tdi), .rec_tdo(rec_tdo), .rec_instr(rec_instr),
    .rec_ovf(rec_ovf), .drop_count(drop_count)
  );

  int checks = 0, failures = 0, cyc = 0;
  int n_exp = 0, n_got = 0;
  logic [1:0]  e_kind [0:511];
  logic [15:0] e_cnt  [0:511];
  logic [63:0] e_di   [0:511];
  logic [63:0] e_do   [0:511];
  logic [4:0]  e_ins  [0:511];
  logic        e_ovf  [0:511];
  logic [1:0]  g_kind [0:511];
  logic [15:0] g_cnt  [0:511];
  logic [63:0] g_di   [0:511];
  logic [63:0] g_do   [0:511];
  logic [4:0]  g_ins  [0:511];
  logic        g_ovf  [0:511];
  logic [4:0]  cur_instr = 5'h08;

  always @(negedge clk) begin
    if (rec_valid && rec_ready && n_got < 512) begin
      g_kind[n_got] = rec_kind; g_cnt[n_got] = rec_count; g_di[n_got] = rec_tdi;
      g_do[n_got] = rec_tdo; g_ins[n_got] = rec_instr; g_ovf[n_got] = rec_ovf;
      n_got++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog expired (no requirement) actual=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input int c, input logic [63:0] d, input logic [63:0] o,
                      input logic [4:0] ins, input logic ov);
    e_kind[n_exp] = k; e_cnt[n_exp] = 16'(c); e_di[n_exp] = d; e_do[n_exp] = o;
    e_ins[n_exp] = ins; e_ovf[n_exp] = ov;
    n_exp++;
  endtask

  task automatic tick(input logic m, input logic d = 1'b0, input logic o = 1'b0);
    @(negedge clk);
    tms = m; tdi = d; tdo = o;
    repeat (4) @(negedge clk);
    tck = 1'b1;
    repeat (4) @(negedge clk);
    tck = 1'b0;
  endtask

  function automatic logic [63:0] lo64(input logic [79:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < 64 && i < n; i++) r[i] = v[i];
    return r;
  endfunction

  // starts and ends in Run-Test/Idle
  task automatic scan(input bit ir, input int n, input logic [79:0] di, input logic [79:0] dq, input int idle);
    logic [63:0] w;
    repeat (idle) tick(1'b0);
    tick(1'b1);
    push(2'd1, idle + 1, '0, '0, cur_instr, 1'b0);
    if (ir) tick(1'b1);
    tick(1'b0);
    if (n == 0) tick(1'b1);
    else begin
      tick(1'b0);
      for (int i = 0; i < n; i++) tick(i == n - 1, di[i], dq[i]);
    end
    tick(1'b1);
    w = lo64(di, n);
    if (ir) cur_instr = w[4:0];
    push(ir ? 2'd2 : 2'd3, n, w, lo64(dq, n), cur_instr, n > 64);
    tick(1'b0);
  endtask

  function automatic logic [79:0] pat_di(input int n);
    logic [79:0] v;
    for (int i = 0; i < 80; i++) v[i] = ((i * 5 + n) % 3) == 0;
    return v;
  endfunction

  function automatic logic [79:0] pat_do(input int n);
    logic [79:0] v;
    for (int i = 0; i < 80; i++) v[i] = ((i * 3 + n * 7) % 5) < 2;
    return v;
  endfunction

  initial begin
    int snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rec_valid == 1'b0, "R9", rec_valid, 0);
    check(drop_count == 0, "R9", drop_count, 0);

    // R5: reset dwell of 3 edges plus the leaving edge
    tick(1'b1); tick(1'b1); tick(1'b1); tick(1'b0);
    push(2'd0, 4, '0, '0, 5'h08, 1'b0);

    // R6: instruction scans of 1..8 bits
    for (int n = 1; n <= 8; n++) begin
      logic [79:0] v = 80'((n * 37 + 5) & 8'hFF);
      scan(1'b1, n, v, pat_do(n), n % 3);
      scan(1'b0, 3, pat_di(n), pat_do(n + 1), 0);
    end

    // R1: line activity with the test clock steady
    snap = n_got;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); tms = i[0]; tdi = i[1]; tdo = i[2];
    end
    repeat (8) @(negedge clk);
    check(n_got == snap, "R1", 128'(n_got), 128'(snap));

    // R3 / R4: data scan length sweep 0..70
    for (int n = 0; n <= 70; n++) scan(1'b0, n, pat_di(n), pat_do(n), n % 4);

    // R7: back to reset through mode select after loading 0x1F
    scan(1'b1, 5, 80'h1F, 80'h0, 1);
    tick(1'b1);
    push(2'd1, 1, '0, '0, cur_instr, 1'b0);
    tick(1'b1); tick(1'b1);
    cur_instr = 5'h08;
    tick(1'b1); tick(1'b1); tick(1'b0);
    push(2'd0, 3, '0, '0, cur_instr, 1'b0);
    scan(1'b0, 6, pat_di(6), pat_do(6), 0);

    // R2: test reset aborts a scan in progress
    scan(1'b1, 5, 80'h1F, 80'h0, 0);
    tick(1'b1);
    push(2'd1, 1, '0, '0, cur_instr, 1'b0);
    tick(1'b0); tick(1'b0);
    tick(1'b0, 1'b1, 1'b1); tick(1'b0, 1'b0, 1'b1);
    @(negedge clk); trst_n = 1'b0;
    tick(1'b0); tick(1'b1);
    @(negedge clk); trst_n = 1'b1;
    cur_instr = 5'h08;
    repeat (4) @(negedge clk);
    tick(1'b1); tick(1'b1); tick(1'b0);
    push(2'd0, 3, '0, '0, cur_instr, 1'b0);
    scan(1'b0, 4, pat_di(4), pat_do(4), 2);

    repeat (12) @(negedge clk);
    check(n_got == n_exp, "R3", 128'(n_got), 128'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      string tag;
      tag = (e_kind[i] < 2) ? "R5" : (e_kind[i] == 2) ? "R6" : (e_cnt[i] > 64) ? "R4" : "R3";
      check({g_kind[i], g_cnt[i], g_di[i], g_do[i], g_ins[i], g_ovf[i]} ==
            {e_kind[i], e_cnt[i], e_di[i], e_do[i], e_ins[i], e_ovf[i]}, tag,
            {g_kind[i], g_cnt[i], g_ins[i], g_ovf[i], g_di[i]},
            {e_kind[i], e_cnt[i], e_ins[i], e_ovf[i], e_di[i]});
      if (e_kind[i] >= 2)
        check(g_do[i] == e_do[i], tag, g_do[i], e_do[i]);
    end

    // R8: back-pressure holds the first record and drops the later ones
    @(negedge clk); rec_ready = 1'b0;
    scan(1'b0, 3, pat_di(3), pat_do(3), 2);
    repeat (8) @(negedge clk);
    check(rec_valid == 1'b1, "R8", rec_valid, 1);
    check(rec_kind == 2'd1 && rec_count == 16'd3, "R8", {rec_kind, rec_count}, {2'd1, 16'd3});
    check(drop_count == 16'd1, "R8", drop_count, 1);
    scan(1'b0, 5, pat_di(5), pat_do(5), 0);
    repeat (8) @(negedge clk);
    check(drop_count == 16'd3, "R8", drop_count, 3);
    check(rec_kind == 2'd1 && rec_count == 16'd3, "R8", {rec_kind, rec_count}, {2'd1, 16'd3});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule